// File: doc/BRIEF.md
# Byte-Addressed GPIO Register Bank

This block is a GPIO controller for up to 56 pins. Software reaches it over a simple synchronous register bus with an 8-bit address, 8-bit data and separate write and read strobes. The per-pin state is held in byte-wide registers with one bit per pin, in five groups: function select, direction, output value, single-bit pull control and a read-only input image. Pins are numbered from 1, so pin p lives at zero-based index p-1, in byte (p-1)/8, bit (p-1)%8 of its group.

A small window of pins (51 to 54 by default) has a packed register that holds a 2-bit bias field per pin. This field replaces the single-bit pull control for those pins. A second register holds a 2-bit input voltage select. Pad inputs pass through a two-flop synchroniser before software can see them. The block drives output enable, output value, pull-up and pull-down controls, and a per-pin logical level toward the pads and the surrounding logic.

Top module: `gpio_reg_bank`

## Requirements
- R1: After reset every register reads 0x00, padOe and padOut are all 0, padPullUp is all 0 and padPullDown is all 1, so every pin starts as an input with pull-down.
- R2: The byte groups sit at select 0x00+n, direction 0x10+n, output 0x20+n, pull-down 0x30+n and input 0x40+n, where n = 0..6. Pin p maps to byte n = (p-1)/8, bit (p-1)%8. Writable groups read back exactly what was written.
- R3: padOe is the direction bit (1 = output, 0 = input) and padOut is the output register bit, at the zero-based index p-1. Only a write to the direction group changes padOe.
- R4: levelOut for a pin is its output register bit when its direction bit is 1, and its synchronised input bit when the direction bit is 0.
- R5: A change on padIn appears in a read of the input group only after two rising edges of clk. A read whose capture edge is the first or the second edge after the change still returns the old value.
- R6: For pins outside the packed window, a pull-down bit of 0 asserts padPullDown and a pull-down bit of 1 releases it. padPullUp stays 0 for these pins.
- R7: The packed bias register at 0x48 holds the field for pin p (51..54) in bits [2*(p-51)+1 : 2*(p-51)]. The codes are 0 = pull-down, 1 or 2 = no pull, 3 = pull-up. Window pins ignore their pull-down bit. padPullUp and padPullDown are never both 1 for a pin.
- R8: The register at 0x47 keeps only its low 2 bits. These drive vselOut, and bits 7:2 read as 0.
- R9: Reads from unmapped addresses return 0x00. Writes to unmapped addresses and to the input group change no state.
- R10: rdData takes the addressed value on the rising edge where rdEn is sampled high, and holds that value until the next read.
- R11: The select group drives altSel, with bit p-1 taken from select byte (p-1)/8, bit (p-1)%8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |
| padIn | input | NUM_PINS | Raw pad input levels |
| padOe | output | NUM_PINS | Output enable per pin |
| padOut | output | NUM_PINS | Output value per pin |
| padPullDown | output | NUM_PINS | Pull-down enable per pin |
| padPullUp | output | NUM_PINS | Pull-up enable per pin |
| altSel | output | NUM_PINS | Function select bit per pin |
| levelOut | output | NUM_PINS | Logical level per pin |
| vselOut | output | 2 | Input voltage select |

## Verification
On every cycle the assertions check several properties:
- no pin ever has pull-up and pull-down asserted together;
- pull-up stays inside the packed window;
- output enables move only on a direction write;
- read data holds between reads;
- unmapped reads and the upper bits of the voltage select come back as zero;
- the decoder never selects a byte beyond the bank.

Only the bench scenarios can show the exact bit position of each pin, the two-edge input latency, the bias code decoding, and the precedence of the direction bit in the level output.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    GRP_NONE, GRP_SEL, GRP_DIR, GRP_OUT, GRP_PD, GRP_IN, GRP_VSEL, GRP_PULL
  } grp_e;

  typedef struct packed {
    logic       wr;
    logic       rd;
    grp_e       grp;
    logic [3:0] byteIdx;
  } bus_stb_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BYTES = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] addr,
  output bus_stb_t   stb
);
  logic [3:0] hiNib, loNib;
  logic       inBank;

  assign hiNib  = addr[7:4];
  assign loNib  = addr[3:0];
  assign inBank = (32'(loNib) < NUM_BYTES);

  always_comb begin
    stb.wr      = wrEn;
    stb.rd      = rdEn;
    stb.byteIdx = loNib;
    stb.grp     = GRP_NONE;
    unique case (hiNib)
      4'h0: if (inBank) stb.grp = GRP_SEL;
      4'h1: if (inBank) stb.grp = GRP_DIR;
      4'h2: if (inBank) stb.grp = GRP_OUT;
      4'h3: if (inBank) stb.grp = GRP_PD;
      4'h4: begin
        if (inBank)             stb.grp = GRP_IN;
        else if (loNib == 4'h7) stb.grp = GRP_VSEL;
        else if (loNib == 4'h8) stb.grp = GRP_PULL;
      end
      default: stb.grp = GRP_NONE;
    endcase
  end

  // R2: a byte-group selection never points past the last byte of the bank
  p_decode_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.grp inside {GRP_SEL, GRP_DIR, GRP_OUT, GRP_PD, GRP_IN}) |-> (32'(stb.byteIdx) < NUM_BYTES));
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS   = 56,
  parameter int PULL_FIRST = 51,
  parameter int PULL_COUNT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  bus_stb_t            stb,
  input  logic [7:0]          wrData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [7:0]          rdData,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPullDown,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] altSel,
  output logic [NUM_PINS-1:0] levelOut,
  output logic [1:0]          vselOut
);
  localparam int NUM_BYTES = (NUM_PINS + 7) / 8;
  localparam int IDXW      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int SLOTS     = 1 << IDXW;
  localparam int PULL_LO   = PULL_FIRST - 1;
  localparam int FIELDW    = 2 * PULL_COUNT;
  localparam logic [NUM_PINS-1:0] WIN_MASK =
    ((NUM_PINS'(1) << PULL_COUNT) - NUM_PINS'(1)) << PULL_LO;

  logic [7:0] selR [NUM_BYTES];
  logic [7:0] dirR [NUM_BYTES];
  logic [7:0] outR [NUM_BYTES];
  logic [7:0] pdR  [NUM_BYTES];
  logic [1:0] vselR;
  logic [FIELDW-1:0] pullR;

  logic [NUM_PINS-1:0] syncA, syncB;
  logic [7:0] selRd [SLOTS];
  logic [7:0] dirRd [SLOTS];
  logic [7:0] outRd [SLOTS];
  logic [7:0] pdRd  [SLOTS];
  logic [7:0] inRd  [SLOTS];

  // Two-flop input synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // Per-byte writable registers
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    localparam int VB = ((NUM_PINS - 8*b) >= 8) ? 8 : (NUM_PINS - 8*b);
    localparam logic [7:0] BMASK = 8'((1 << VB) - 1);
    logic hit;
    assign hit = stb.wr && (32'(stb.byteIdx) == b);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selR[b] <= '0;
        dirR[b] <= '0;
        outR[b] <= '0;
        pdR[b]  <= '0;
      end else if (hit) begin
        case (stb.grp)
          GRP_SEL: selR[b] <= wrData & BMASK;
          GRP_DIR: dirR[b] <= wrData & BMASK;
          GRP_OUT: outR[b] <= wrData & BMASK;
          GRP_PD:  pdR[b]  <= wrData & BMASK;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vselR <= '0;
      pullR <= '0;
    end else if (stb.wr) begin
      if (stb.grp == GRP_VSEL) vselR <= wrData[1:0];
      if (stb.grp == GRP_PULL) pullR <= wrData[FIELDW-1:0];
    end
  end

  // Read slots, padded to a power of two
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NUM_BYTES) begin : g_live
      assign selRd[s] = selR[s];
      assign dirRd[s] = dirR[s];
      assign outRd[s] = outR[s];
      assign pdRd[s]  = pdR[s];
      for (genvar k = 0; k < 8; k++) begin : g_in
        if (8*s + k < NUM_PINS) begin : g_pin
          assign inRd[s][k] = syncB[8*s + k];
        end else begin : g_pad
          assign inRd[s][k] = 1'b0;
        end
      end
    end else begin : g_dead
      assign selRd[s] = '0;
      assign dirRd[s] = '0;
      assign outRd[s] = '0;
      assign pdRd[s]  = '0;
      assign inRd[s]  = '0;
    end
  end

  logic [IDXW-1:0] rdIdx;
  logic [7:0]      rdNext;
  assign rdIdx = stb.byteIdx[IDXW-1:0];

  always_comb begin
    case (stb.grp)
      GRP_SEL:  rdNext = selRd[rdIdx];
      GRP_DIR:  rdNext = dirRd[rdIdx];
      GRP_OUT:  rdNext = outRd[rdIdx];
      GRP_PD:   rdNext = pdRd[rdIdx];
      GRP_IN:   rdNext = inRd[rdIdx];
      GRP_VSEL: rdNext = {6'b0, vselR};
      GRP_PULL: rdNext = 8'(pullR);
      default:  rdNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rdData <= '0;
    else if (stb.rd) rdData <= rdNext;
  end

  // Pad-side decode
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign padOe[i]    = dirR[i/8][i%8];
    assign padOut[i]   = outR[i/8][i%8];
    assign altSel[i]   = selR[i/8][i%8];
    assign levelOut[i] = dirR[i/8][i%8] ? outR[i/8][i%8] : syncB[i];
    if (i >= PULL_LO && i < PULL_LO + PULL_COUNT) begin : g_win
      logic [1:0] code;
      assign code           = pullR[2*(i-PULL_LO) +: 2];
      assign padPullDown[i] = (code == 2'd0);
      assign padPullUp[i]   = (code == 2'd3);
    end else begin : g_std
      assign padPullDown[i] = ~pdR[i/8][i%8];
      assign padPullUp[i]   = 1'b0;
    end
  end

  assign vselOut = vselR;

  // R7: pull-up and pull-down never both active on a pin
  p_bias_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padPullDown) == '0);
  // R6: pull-up only appears inside the packed window
  p_pullup_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & ~WIN_MASK) == '0);
  // R3: output enables change only through a direction write
  p_oe_only_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr && stb.grp == GRP_DIR) |=> $stable(padOe));
  // R10: read data holds when no read is issued
  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rd |=> $stable(rdData));
  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && stb.grp == GRP_NONE) |=> (rdData == 8'h00));
  // R8: upper bits of the voltage select read as zero
  p_vsel_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && stb.grp == GRP_VSEL) |=> (rdData[7:2] == 6'b0));
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS   = 56,
  parameter int PULL_FIRST = 51,
  parameter int PULL_COUNT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [7:0]          addr,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPullDown,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] altSel,
  output logic [NUM_PINS-1:0] levelOut,
  output logic [1:0]          vselOut
);
  localparam int NUM_BYTES = (NUM_PINS + 7) / 8;

  bus_stb_t stb;

  gpio_bank_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb)
  );

  gpio_bank_datapath #(
    .NUM_PINS(NUM_PINS), .PULL_FIRST(PULL_FIRST), .PULL_COUNT(PULL_COUNT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .padIn(padIn),
    .rdData(rdData), .padOe(padOe), .padOut(padOut),
    .padPullDown(padPullDown), .padPullUp(padPullUp), .altSel(altSel),
    .levelOut(levelOut), .vselOut(vselOut)
  );
endmodule

// File: tb/tb_gpio_reg_bank.sv
module tb_gpio_reg_bank;
  localparam int NP = 56;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0, wrData = '0;
  logic [7:0] rdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOe, padOut, padPullDown, padPullUp, altSel, levelOut;
  logic [1:0] vselOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  gpio_reg_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .padPullDown(padPullDown), .padPullUp(padPullUp),
    .altSel(altSel), .levelOut(levelOut), .vselOut(vselOut)
  );

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] w;
    logic [7:0] e;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h3C, 8'h3C},  // R2 R11 select byte 0
    '{8'h13, 8'h5A, 8'h5A},  // R2 direction byte 3
    '{8'h26, 8'hA5, 8'hA5},  // R2 output byte 6
    '{8'h32, 8'h0F, 8'h0F},  // R2 pull-down byte 2
    '{8'h48, 8'hE4, 8'hE4},  // R7 packed bias readback
    '{8'h47, 8'hFF, 8'h03},  // R8 voltage select keeps 2 bits
    '{8'h07, 8'hFF, 8'h00},  // R9 unmapped
    '{8'h49, 8'h77, 8'h00},  // R9 unmapped
    '{8'h55, 8'h12, 8'h00},  // R9 unmapped
    '{8'h40, 8'hFF, 8'h00},  // R9 input group is read-only
    '{8'h16, 8'h81, 8'h81}   // R2 direction byte 6
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] r;
    logic [NP-1:0] oeSnap, selSnap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(padOe == '0, "R1 padOe", 64'(padOe), 0);
    check(padOut == '0, "R1 padOut", 64'(padOut), 0);
    check(padPullUp == '0, "R1 padPullUp", 64'(padPullUp), 0);
    check(padPullDown == '1, "R1 padPullDown", 64'(padPullDown), {8'h0, 56'hFFFFFFFFFFFFFF});
    busRead(8'h20, r);
    check(r == 8'h00, "R1 output reg", 64'(r), 0);
    busRead(8'h48, r);
    check(r == 8'h00, "R1 bias reg", 64'(r), 0);

    // Table walk: write then read back
    for (int k = 0; k < NV; k++) begin
      busWrite(VECS[k].a, VECS[k].w);
      busRead(VECS[k].a, r);
      check(r == VECS[k].e, $sformatf("R2/R7/R8/R9 vector %0d", k), 64'(r), 64'(VECS[k].e));
    end

    // R3 R11 R8 port view after the table
    check(padOe[31:24] == 8'h5A, "R3 padOe byte3", 64'(padOe[31:24]), 64'h5A);
    check(padOe[55:48] == 8'h81, "R3 padOe byte6", 64'(padOe[55:48]), 64'h81);
    check(padOut[55:48] == 8'hA5, "R3 padOut byte6", 64'(padOut[55:48]), 64'hA5);
    check(altSel[7:0] == 8'h3C, "R11 altSel byte0", 64'(altSel[7:0]), 64'h3C);
    check(vselOut == 2'd3, "R8 vselOut", 64'(vselOut), 3);

    // R9 unmapped write leaves ports untouched
    oeSnap = padOe; selSnap = altSel;
    busWrite(8'h08, 8'hFF);
    busWrite(8'h0F, 8'hFF);
    check(padOe == oeSnap && altSel == selSnap, "R9 unmapped write no effect", 64'(altSel), 64'(selSnap));

    // R6 single-bit pull scheme
    busWrite(8'h30, 8'h0F);
    check(padPullDown[7:0] == 8'hF0, "R6 pull-down byte0", 64'(padPullDown[7:0]), 64'hF0);
    check(padPullUp[7:0] == 8'h00, "R6 no pull-up byte0", 64'(padPullUp[7:0]), 0);

    // R7 packed field, window pins ignore pull-down bit (bias 0xE4 still set)
    busWrite(8'h36, 8'hFF);
    check(padPullDown[55:48] == 8'h04, "R7 pull-down byte6 E4", 64'(padPullDown[55:48]), 64'h04);
    check(padPullUp[55:48] == 8'h20, "R7 pull-up byte6 E4", 64'(padPullUp[55:48]), 64'h20);
    busWrite(8'h48, 8'h1B);
    check(padPullDown[55:48] == 8'h20, "R7 pull-down byte6 1B", 64'(padPullDown[55:48]), 64'h20);
    check(padPullUp[55:48] == 8'h04, "R7 pull-up byte6 1B", 64'(padPullUp[55:48]), 64'h04);

    // R4 level output
    busWrite(8'h10, 8'h0F);
    busWrite(8'h20, 8'h05);
    @(negedge clk);
    padIn[7:0] = 8'hA0;
    repeat (3) @(negedge clk);
    check(levelOut[7:0] == 8'hA5, "R4 levelOut byte0", 64'(levelOut[7:0]), 64'hA5);

    // R5 two-edge synchroniser latency, continuous read of 0x41
    @(negedge clk);
    padIn[15:8] = 8'h3C;
    rdEn = 1'b1; addr = 8'h41;
    @(negedge clk);
    check(rdData == 8'h00, "R5 after edge 1", 64'(rdData), 0);
    @(negedge clk);
    check(rdData == 8'h00, "R5 after edge 2", 64'(rdData), 0);
    @(negedge clk);
    check(rdData == 8'h3C, "R5 after edge 3", 64'(rdData), 64'h3C);
    rdEn = 1'b0;

    // R9 write to input group ignored
    busWrite(8'h41, 8'h00);
    busRead(8'h41, r);
    check(r == 8'h3C, "R9 input write ignored", 64'(r), 64'h3C);

    // R10 read data holds between reads
    busRead(8'h20, r);
    check(r == 8'h05, "R10 read output byte0", 64'(r), 64'h05);
    busWrite(8'h20, 8'hFF);
    @(negedge clk);
    check(rdData == 8'h05, "R10 rdData holds", 64'(rdData), 64'h05);

    finishRun();
  end
endmodule